// File: doc/BRIEF.md
# Processor Port Bus Bridge for a Time-Interval Measurement Unit

This block sits between the 8-bit port bus of a small soft processor and the peripherals of a time-interval measurement unit. The processor drives a port number, a write byte and separate read and write strobes. It takes back a read byte. The bridge decodes the port number into read selections and into single-cycle command pulses. The read sources are the two bytes of the coarse cycle count, the fine interpolation count, the head of a measurement FIFO, a received UART byte and a packed status byte. The commands are FIFO pop, FIFO push, UART receive acknowledge, measurement acknowledge and the two halves of a 16-bit DAC control word.

Each bus access spans two clock cycles. The port number is held for both cycles, and the strobe is raised only in the second cycle. The bridge registers every read source at the end of the first cycle, and this also brings UART-side values onto the bridge's clock. A second multiplexer level then chooses among the registered UART data, the registered status and the registered measurement byte, so the read byte is steady for the whole of the second cycle. Side effects are tied to the strobe, so each access pops or acknowledges exactly once.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is asserted, `in_port` is 0x00, `dac_code` is 0x0000, and `fifo_pop`, `fifo_push`, `uart_rd_ack` and `meas_ack` are all low.
- R2: The read byte for the port held during the first cycle of an access shows on `in_port` throughout the second cycle. It carries the source values present at the clock edge that ends the first cycle, and changes to a source after that edge do not alter it.
- R3: Port 0x00 returns `coarse_cnt[7:0]`, port 0x01 returns `coarse_cnt[15:8]` and port 0x02 returns `fine_cnt`.
- R4: Port 0x03 returns `fifo_rd_data`. `fifo_pop` is high for exactly the one cycle in which `rd_strobe` is high with port 0x03, and it stays low while the port is held without a strobe.
- R5: Port 0x04 returns `uart_rx_data`. `uart_rd_ack` pulses for one cycle only on a strobed read of port 0x04.
- R6: Port 0x05 returns a status byte with bit0 = `fifo_empty`, bit1 = `fifo_full`, bit2 = `uart_rx_avail` and bit3 = `meas_ready`. Bits 7..4 are 0.
- R7: A strobed read of port 0x02 pulses `meas_ack` for one cycle.
- R8: A read of any port other than 0x00 to 0x05 returns 0x00.
- R9: A strobed write to port 0x10 stages the low DAC byte and leaves `dac_code` unchanged. A strobed write to port 0x11 loads `dac_code` with {write byte, staged byte} at the edge that ends the access, and `dac_code` holds its value otherwise.
- R10: A strobed write to port 0x03 pulses `fifo_push` for one cycle, with `fifo_wr_data` equal to the write byte.
- R11: A strobe in the wrong direction has no effect. A write strobe at ports 0x02, 0x03 or 0x04 gives no `meas_ack`, `fifo_pop` or `uart_rd_ack`, and a read strobe at 0x10 or 0x11 leaves `dac_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 8 | Port number, held for both cycles of an access |
| rd_strobe | input | 1 | Read strobe, second cycle only |
| wr_strobe | input | 1 | Write strobe, second cycle only |
| out_port | input | 8 | Write byte from the processor |
| in_port | output | 8 | Read byte to the processor |
| coarse_cnt | input | 16 | Coarse cycle count |
| fine_cnt | input | 8 | Fine interpolation count |
| meas_ready | input | 1 | A new measurement is available |
| meas_ack | output | 1 | Measurement acknowledge pulse |
| fifo_rd_data | input | 8 | Byte at the FIFO head |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| fifo_pop | output | 1 | FIFO pop pulse |
| fifo_push | output | 1 | FIFO push pulse |
| fifo_wr_data | output | 8 | Byte to push into the FIFO |
| uart_rx_data | input | 8 | Received UART byte |
| uart_rx_avail | input | 1 | UART byte waiting |
| uart_rd_ack | output | 1 | UART receive acknowledge pulse |
| dac_code | output | 16 | DAC control word |

## Verification
The hardest case to reach from the ports is a source that changes between the capture edge and the processor's sample, because a combinational read path would pass the new value through without any visible sign. The bench produces this on purpose. It presents the port, lets the capture edge pass, changes the coarse count in the same half cycle that raises the strobe, and then expects the old byte on one access and the new byte on the next. The second hard case is a DAC word that changes partway through, and it is covered by checking `dac_code` after the low-byte write and before the high-byte write.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam logic [7:0] P_CNT_LO = 8'h00;
  localparam logic [7:0] P_CNT_HI = 8'h01;
  localparam logic [7:0] P_FINE   = 8'h02;
  localparam logic [7:0] P_FIFO   = 8'h03;
  localparam logic [7:0] P_UDATA  = 8'h04;
  localparam logic [7:0] P_USTAT  = 8'h05;
  localparam logic [7:0] P_DAC_LO = 8'h10;
  localparam logic [7:0] P_DAC_HI = 8'h11;

  // second-level read selection
  typedef enum logic [1:0] {
    OSEL_ZERO  = 2'd0,
    OSEL_MEAS  = 2'd1,
    OSEL_UDATA = 2'd2,
    OSEL_USTAT = 2'd3
  } osel_e;

  // first-level read selection (index into measurement sources)
  typedef enum logic [1:0] {
    MSEL_LO   = 2'd0,
    MSEL_HI   = 2'd1,
    MSEL_FINE = 2'd2,
    MSEL_FIFO = 2'd3
  } msel_e;
endpackage

// File: rtl/pbus_addr_dec.sv
module pbus_addr_dec
  import pbus_pkg::*;
(
  input  logic [7:0] port_addr,
  input  logic       rd_stb,
  input  logic       wr_stb,
  output osel_e      osel,
  output msel_e      msel,
  output logic       pop_fifo,
  output logic       ack_uart,
  output logic       ack_meas,
  output logic       push_fifo,
  output logic       wr_dac_lo,
  output logic       wr_dac_hi
);
  always_comb begin
    osel = OSEL_ZERO;
    msel = MSEL_LO;
    unique case (port_addr)
      P_CNT_LO: begin osel = OSEL_MEAS; msel = MSEL_LO;   end
      P_CNT_HI: begin osel = OSEL_MEAS; msel = MSEL_HI;   end
      P_FINE:   begin osel = OSEL_MEAS; msel = MSEL_FINE; end
      P_FIFO:   begin osel = OSEL_MEAS; msel = MSEL_FIFO; end
      P_UDATA:  osel = OSEL_UDATA;
      P_USTAT:  osel = OSEL_USTAT;
      default:  osel = OSEL_ZERO;
    endcase
  end

  assign pop_fifo  = rd_stb && (port_addr == P_FIFO);
  assign ack_uart  = rd_stb && (port_addr == P_UDATA);
  assign ack_meas  = rd_stb && (port_addr == P_FINE);
  assign push_fifo = wr_stb && (port_addr == P_FIFO);
  assign wr_dac_lo = wr_stb && (port_addr == P_DAC_LO);
  assign wr_dac_hi = wr_stb && (port_addr == P_DAC_HI);
endmodule

// File: rtl/pbus_rd_path.sv
module pbus_rd_path
  import pbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  osel_e         osel,
  input  msel_e         msel,
  input  logic [CW-1:0] coarse,
  input  logic [DW-1:0] fine,
  input  logic [DW-1:0] fifo_data,
  input  logic [DW-1:0] udata,
  input  logic [DW-1:0] ustat,
  output logic [DW-1:0] rd_data
);
  localparam int NBYTE = CW / DW;
  localparam int NSRC  = NBYTE + 2;

  logic [DW-1:0] msrc [NSRC];
  logic [DW-1:0] meas_d, meas_q;
  logic [DW-1:0] udata_d, udata_q;
  logic [DW-1:0] ustat_d, ustat_q;
  osel_e         osel_d, osel_q;

  genvar g;
  generate
    for (g = 0; g < NBYTE; g++) begin : g_cnt_byte
      assign msrc[g] = coarse[g*DW +: DW];
    end
  endgenerate
  assign msrc[NBYTE]   = fine;
  assign msrc[NBYTE+1] = fifo_data;

  // next-state: first mux level and capture of UART-side values
  always_comb begin
    meas_d  = meas_q;
    udata_d = udata_q;
    ustat_d = ustat_q;
    osel_d  = osel_q;
    if (cap_en) begin
      meas_d  = msrc[int'(msel)];
      udata_d = udata;
      ustat_d = ustat;
      osel_d  = osel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q  <= '0;
      udata_q <= '0;
      ustat_q <= '0;
      osel_q  <= OSEL_ZERO;
    end else begin
      meas_q  <= meas_d;
      udata_q <= udata_d;
      ustat_q <= ustat_d;
      osel_q  <= osel_d;
    end
  end

  // second mux level, from registered values only
  always_comb begin
    unique case (osel_q)
      OSEL_MEAS:  rd_data = meas_q;
      OSEL_UDATA: rd_data = udata_q;
      OSEL_USTAT: rd_data = ustat_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pbus_dac_regs.sv
module pbus_dac_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] dac_code
);
  logic [DW-1:0]   lo_d, lo_q;
  logic [2*DW-1:0] code_d, code_q;

  always_comb begin
    lo_d   = lo_q;
    code_d = code_q;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) code_d = {wdata, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      code_q <= '0;
    end else begin
      lo_q   <= lo_d;
      code_q <= code_d;
    end
  end

  assign dac_code = code_q;
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    port_addr,
  input  logic          rd_strobe,
  input  logic          wr_strobe,
  input  logic [DW-1:0] out_port,
  output logic [DW-1:0] in_port,
  input  logic [CW-1:0] coarse_cnt,
  input  logic [DW-1:0] fine_cnt,
  input  logic          meas_ready,
  output logic          meas_ack,
  input  logic [DW-1:0] fifo_rd_data,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wr_data,
  input  logic [DW-1:0] uart_rx_data,
  input  logic          uart_rx_avail,
  output logic          uart_rd_ack,
  output logic [2*DW-1:0] dac_code
);
  localparam int NFLAG = 4;

  osel_e         osel;
  msel_e         msel;
  logic          wr_dac_lo, wr_dac_hi;
  logic          cap_en;
  logic [DW-1:0] status;

  assign status = {{(DW-NFLAG){1'b0}}, meas_ready, uart_rx_avail, fifo_full, fifo_empty};
  assign cap_en = !(rd_strobe || wr_strobe);

  pbus_addr_dec u_dec (
    .port_addr (port_addr),
    .rd_stb    (rd_strobe),
    .wr_stb    (wr_strobe),
    .osel      (osel),
    .msel      (msel),
    .pop_fifo  (fifo_pop),
    .ack_uart  (uart_rd_ack),
    .ack_meas  (meas_ack),
    .push_fifo (fifo_push),
    .wr_dac_lo (wr_dac_lo),
    .wr_dac_hi (wr_dac_hi)
  );

  pbus_rd_path #(.DW(DW), .CW(CW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .osel      (osel),
    .msel      (msel),
    .coarse    (coarse_cnt),
    .fine      (fine_cnt),
    .fifo_data (fifo_rd_data),
    .udata     (uart_rx_data),
    .ustat     (status),
    .rd_data   (in_port)
  );

  pbus_dac_regs #(.DW(DW)) u_dac (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_dac_lo),
    .wr_hi    (wr_dac_hi),
    .wdata    (out_port),
    .dac_code (dac_code)
  );

  assign fifo_wr_data = out_port;
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  port_addr,
  input logic        rd_strobe,
  input logic        wr_strobe,
  input logic [7:0]  out_port,
  input logic [7:0]  in_port,
  input logic [15:0] coarse_cnt,
  input logic        fifo_pop,
  input logic        fifo_push,
  input logic        uart_rd_ack,
  input logic        meas_ack,
  input logic [15:0] dac_code
);
  logic unmapped;
  logic idle;
  assign unmapped = port_addr > 8'h05;
  assign idle     = !rd_strobe && !wr_strobe;

  // R3: low count byte reaches the read bus one cycle after the port is presented
  p_cnt_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_addr == 8'h00 && idle) |=> in_port == $past(coarse_cnt[7:0]));

  // R4: no pop without a read strobe
  p_pop_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> rd_strobe);

  // R11: at most one command pulse per cycle
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_pop, fifo_push, uart_rd_ack, meas_ack}));

  // R8: unmapped port reads as zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped && idle) |=> in_port == 8'h00);

  // R6: upper status bits are zero
  p_status_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_addr == 8'h05 && idle) |=> in_port[7:4] == 4'h0);

  // R9: DAC word holds unless the high byte is written
  p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && port_addr == 8'h11) |=> $stable(dac_code));

  // R9: high-byte write loads the upper DAC byte
  p_dac_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && port_addr == 8'h11) |=> dac_code[15:8] == $past(out_port));
endmodule

bind pbus_bridge pbus_bridge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_addr   (port_addr),
  .rd_strobe   (rd_strobe),
  .wr_strobe   (wr_strobe),
  .out_port    (out_port),
  .in_port     (in_port),
  .coarse_cnt  (coarse_cnt),
  .fifo_pop    (fifo_pop),
  .fifo_push   (fifo_push),
  .uart_rd_ack (uart_rd_ack),
  .meas_ack    (meas_ack),
  .dac_code    (dac_code)
);

// File: tb/sim_pbus_bridge.sv
module sim_pbus_bridge;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // {port, expected byte, pop, uart ack, meas ack}
  localparam logic [18:0] VEC [NV] = '{
    {8'h00, 8'hC3, 3'b000},
    {8'h01, 8'hA5, 3'b000},
    {8'h02, 8'h3E, 3'b001},
    {8'h03, 8'h77, 3'b100},
    {8'h04, 8'h9B, 3'b010},
    {8'h05, 8'h0E, 3'b000},
    {8'h06, 8'h00, 3'b000},
    {8'h10, 8'h00, 3'b000},
    {8'h11, 8'h00, 3'b000},
    {8'hFF, 8'h00, 3'b000}
  };

  logic        clk, rst_n;
  logic [7:0]  port_addr, out_port, in_port;
  logic        rd_strobe, wr_strobe;
  logic [15:0] coarse_cnt, dac_code;
  logic [7:0]  fine_cnt, fifo_rd_data, fifo_wr_data, uart_rx_data;
  logic        meas_ready, meas_ack, fifo_empty, fifo_full, fifo_pop, fifo_push;
  logic        uart_rx_avail, uart_rd_ack;

  int nchk, nerr;
  logic [7:0] s_rd, s_pushd;
  logic       s_pre, s_pop, s_uack, s_mack, s_push;

  pbus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .out_port(out_port), .in_port(in_port),
    .coarse_cnt(coarse_cnt), .fine_cnt(fine_cnt), .meas_ready(meas_ready),
    .meas_ack(meas_ack), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
    .fifo_wr_data(fifo_wr_data), .uart_rx_data(uart_rx_data),
    .uart_rx_avail(uart_rx_avail), .uart_rd_ack(uart_rd_ack), .dac_code(dac_code)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // two-cycle access; samples read byte and pulses
  task automatic acc(input logic [7:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    port_addr = a; out_port = d; rd_strobe = 1'b0; wr_strobe = 1'b0;
    @(negedge clk);
    s_rd  = in_port;
    s_pre = fifo_pop | uart_rd_ack | meas_ack | fifo_push;
    rd_strobe = !w; wr_strobe = w;
    #1;
    s_pop = fifo_pop; s_uack = uart_rd_ack; s_mack = meas_ack;
    s_push = fifo_push; s_pushd = fifo_wr_data;
    @(negedge clk);
    rd_strobe = 1'b0; wr_strobe = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; port_addr = 8'h00; out_port = 8'h00;
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    coarse_cnt = 16'hA5C3; fine_cnt = 8'h3E; fifo_rd_data = 8'h77;
    uart_rx_data = 8'h9B; fifo_empty = 1'b0; fifo_full = 1'b1;
    uart_rx_avail = 1'b1; meas_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in_port", {8'h0, in_port}, 16'h0);
    chk("R1 dac_code", dac_code, 16'h0);
    chk("R1 pulses", {12'h0, fifo_pop, fifo_push, uart_rd_ack, meas_ack}, 16'h0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8: table walk of reads
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][18:11], 8'h00, 1'b0);
      chk($sformatf("R3/R4/R5/R6/R8 read port %h", VEC[i][18:11]), {8'h0, s_rd}, {8'h0, VEC[i][10:3]});
      chk($sformatf("R4 R5 R7 pulses port %h", VEC[i][18:11]),
          {13'h0, s_pop, s_uack, s_mack}, {13'h0, VEC[i][2:0]});
      chk("R4 no pulse before strobe", {15'h0, s_pre}, 16'h0);
    end

    // R6: other status pattern
    fifo_empty = 1'b1; fifo_full = 1'b0; uart_rx_avail = 1'b0; meas_ready = 1'b0;
    acc(8'h05, 8'h00, 1'b0);
    chk("R6 status empty only", {8'h0, s_rd}, 16'h0001);

    // R2: source changes after capture edge
    @(negedge clk);
    port_addr = 8'h00; coarse_cnt = 16'h1111;
    @(negedge clk);
    coarse_cnt = 16'h2222; rd_strobe = 1'b1;
    #1;
    chk("R2 held byte", {8'h0, in_port}, 16'h0011);
    @(negedge clk);
    rd_strobe = 1'b0;
    acc(8'h00, 8'h00, 1'b0);
    chk("R2 next access new byte", {8'h0, s_rd}, 16'h0022);

    // R9: staged DAC write
    acc(8'h10, 8'h34, 1'b1);
    chk("R9 low write no change", dac_code, 16'h0000);
    acc(8'h11, 8'h12, 1'b1);
    chk("R9 high write loads", dac_code, 16'h1234);
    acc(8'h11, 8'hAB, 1'b1);
    chk("R9 reuses staged low", dac_code, 16'hAB34);

    // R10: FIFO push
    acc(8'h03, 8'h5A, 1'b1);
    chk("R10 push pulse", {15'h0, s_push}, 16'h1);
    chk("R10 push data", {8'h0, s_pushd}, 16'h005A);
    chk("R11 no pop on write strobe", {15'h0, s_pop}, 16'h0);

    // R11: wrong-direction strobes
    acc(8'h04, 8'h00, 1'b1);
    chk("R11 no uart ack on write", {15'h0, s_uack}, 16'h0);
    acc(8'h02, 8'h00, 1'b1);
    chk("R11 no meas ack on write", {15'h0, s_mack}, 16'h0);
    acc(8'h11, 8'h00, 1'b0);
    chk("R11 read at DAC port keeps code", dac_code, 16'hAB34);
    acc(8'h10, 8'h99, 1'b0);
    acc(8'h11, 8'h01, 1'b1);
    chk("R11 read at 0x10 did not stage", dac_code, 16'h0134);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule